// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block generates the column addresses for a single SDRAM read or write burst. A command stage pulses `cmd_go` together with the starting column, the burst-length code and the ordering bit. Those three values are captured only on that pulse. Starting on the next clock, the block presents one column per cycle on `beat_col`, qualified by `beat_valid`.

The burst moves through an aligned window whose size is the burst length. In linear order the low bits count upward and wrap inside the window. In interleaved order the low bits are the start offset XOR the beat number. A full-page burst covers every column of the row, wraps from the top column to zero, and runs until something ends it.

`beat_last` marks the final beat of a fixed-length burst. A stop pulse ends any burst on the following clock. A new command pulse restarts the sequence at once, at any point of a running burst.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first `cmd_go`, `beat_valid` and `beat_last` are 0.
- R2: When `cmd_go` is high at a clock edge, `beat_valid` is 1 from the next cycle on, and `beat_col` equals the sampled `cmd_col`. After that, one new beat is presented per clock.
- R3: The `cmd_len` code sets the number of beats: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. The codes 4, 5 and 6 act as 1. After the last beat of a fixed-length burst, `beat_valid` is 0 in the next cycle unless a new `cmd_go` arrives.
- R4: With `cmd_ilv`=0 and length L, beat k is `base + ((off + k) mod L)`, where `off = cmd_col mod L` and `base = cmd_col - off`.
- R5: With `cmd_ilv`=1 and length L, beat k is `base + (off XOR k)`, using the same `off` and `base` as in R4.
- R6: `beat_last` is 1 exactly on beat L-1 of a fixed-length burst and is never 1 when `beat_valid` is 0.
- R7: A full-page burst treats L as 2^COL_W (512 by default), so it wraps from column 511 to column 0. It never raises `beat_last` and keeps running until stopped or restarted.
- R8: A `brk` pulse with no `cmd_go` in the same cycle makes `beat_valid` 0 in the next cycle. When no burst is running, `brk` has no effect.
- R9: A `cmd_go` during a running burst restarts the sequence at the new column, length and order. If `cmd_go` and `brk` are high in the same cycle, `cmd_go` wins. A `cmd_go` on the last beat gives back-to-back beats with no gap.
- R10: Changes on `cmd_col`, `cmd_len` and `cmd_ilv` while `cmd_go` is low do not alter a running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_go | input | 1 | Read/write command accepted; starts a burst |
| cmd_col | input | COL_W | Starting column |
| cmd_len | input | 3 | Burst length code |
| cmd_ilv | input | 1 | 0 = linear order, 1 = interleaved order |
| brk | input | 1 | Burst stop |
| beat_valid | output | 1 | A column is presented this cycle |
| beat_col | output | COL_W | Current column address |
| beat_last | output | 1 | Final beat of a fixed-length burst |

## Verification
Three events can fall on the same clock edge: a stop, a new command, and the natural end of a fixed-length burst. The bench provokes a command and a stop together in the middle of an 8-beat burst. It then checks that the new sequence starts in the very next cycle and that no idle cycle appears. It also issues a command on the cycle a 2-beat burst shows its last beat, and checks that the new burst's first column follows with no gap.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int unsigned LEN_CODE_W = 3;
  localparam logic [LEN_CODE_W-1:0] LEN_ONE   = 3'd0;
  localparam logic [LEN_CODE_W-1:0] LEN_TWO   = 3'd1;
  localparam logic [LEN_CODE_W-1:0] LEN_FOUR  = 3'd2;
  localparam logic [LEN_CODE_W-1:0] LEN_EIGHT = 3'd3;
  localparam logic [LEN_CODE_W-1:0] LEN_PAGE  = 3'd7;

  // log2 of the window size for fixed-length codes; reserved codes act as 1
  function automatic int unsigned win_log2(input logic [LEN_CODE_W-1:0] code);
    case (code)
      LEN_TWO:   return 1;
      LEN_FOUR:  return 2;
      LEN_EIGHT: return 3;
      default:   return 0;
    endcase
  endfunction
endpackage

// File: rtl/bcg_mode_decode.sv
module bcg_mode_decode
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [LEN_CODE_W-1:0] len_code,
  output logic [COL_W-1:0]      win_mask,
  output logic                  page_mode
);
  logic [31:0] lg;

  always_comb begin
    page_mode = (len_code == LEN_PAGE);
    lg        = 32'(win_log2(len_code));
  end

  // one mask bit per column bit: set if inside the wrap window
  for (genvar b = 0; b < int'(COL_W); b++) begin : g_mask
    assign win_mask[b] = page_mode | (lg > 32'(b));
  end
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map #(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] origin,
  input  logic [COL_W-1:0] beat_idx,
  input  logic [COL_W-1:0] win_mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  function automatic logic [COL_W-1:0] linear_col(
    input logic [COL_W-1:0] s, input logic [COL_W-1:0] k, input logic [COL_W-1:0] m);
    return (s & ~m) | ((s + k) & m);
  endfunction

  function automatic logic [COL_W-1:0] xor_col(
    input logic [COL_W-1:0] s, input logic [COL_W-1:0] k, input logic [COL_W-1:0] m);
    return (s & ~m) | ((s ^ k) & m);
  endfunction

  always_comb begin
    col = ilv ? xor_col(origin, beat_idx, win_mask)
              : linear_col(origin, beat_idx, win_mask);
  end
endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [COL_W-1:0] go_col,
  input  logic [COL_W-1:0] go_mask,
  input  logic             go_page,
  input  logic             go_ilv,
  input  logic             brk,
  output logic             running,
  output logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] origin,
  output logic [COL_W-1:0] mask,
  output logic             page,
  output logic             ilv,
  output logic             at_end
);
  assign at_end = running & ~page & (idx == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      idx     <= '0;
      origin  <= '0;
      mask    <= '0;
      page    <= 1'b0;
      ilv     <= 1'b0;
    end else if (go) begin
      running <= 1'b1;
      idx     <= '0;
      origin  <= go_col;
      mask    <= go_mask;
      page    <= go_page;
      ilv     <= go_ilv;
    end else if (brk || at_end) begin
      running <= 1'b0;
    end else if (running) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_go,
  input  logic [COL_W-1:0]      cmd_col,
  input  logic [LEN_CODE_W-1:0] cmd_len,
  input  logic                  cmd_ilv,
  input  logic                  brk,
  output logic                  beat_valid,
  output logic [COL_W-1:0]      beat_col,
  output logic                  beat_last
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic             run_q;
  logic [COL_W-1:0] idx_q, origin_q, mask_q;
  logic             page_q, ilv_q, end_beat;

  bcg_mode_decode #(.COL_W(COL_W)) u_dec (
    .len_code (cmd_len),
    .win_mask (dec_mask),
    .page_mode(dec_page)
  );

  bcg_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (cmd_go),
    .go_col (cmd_col),
    .go_mask(dec_mask),
    .go_page(dec_page),
    .go_ilv (cmd_ilv),
    .brk    (brk),
    .running(run_q),
    .idx    (idx_q),
    .origin (origin_q),
    .mask   (mask_q),
    .page   (page_q),
    .ilv    (ilv_q),
    .at_end (end_beat)
  );

  bcg_addr_map #(.COL_W(COL_W)) u_map (
    .origin  (origin_q),
    .beat_idx(idx_q),
    .win_mask(mask_q),
    .ilv     (ilv_q),
    .col     (beat_col)
  );

  assign beat_valid = run_q;
  assign beat_last  = end_beat;
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int unsigned COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_go,
  input logic [COL_W-1:0] cmd_col,
  input logic             brk,
  input logic             beat_valid,
  input logic [COL_W-1:0] beat_col,
  input logic             beat_last,
  input logic             burst_page,
  input logic             burst_ilv,
  input logic [COL_W-1:0] burst_mask
);
  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> beat_valid && beat_col == $past(cmd_col));

  assert_end_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last && !cmd_go |=> !beat_valid);

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last && !brk && !cmd_go && !burst_ilv |=>
      ((beat_col & burst_mask) == (($past(beat_col) + 1'b1) & burst_mask)) &&
      ((beat_col & ~burst_mask) == ($past(beat_col) & ~burst_mask)));

  assert_last_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

  assert_page_no_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_page |-> !beat_last);

  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk && !cmd_go |=> !beat_valid);

  assert_keep_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last && !brk |=> beat_valid);
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_go    (cmd_go),
  .cmd_col   (cmd_col),
  .brk       (brk),
  .beat_valid(beat_valid),
  .beat_col  (beat_col),
  .beat_last (beat_last),
  .burst_page(page_q),
  .burst_ilv (ilv_q),
  .burst_mask(mask_q)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;
  localparam int COL_W = 9;
  localparam int PAGE = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_go = 1'b0;
  logic [COL_W-1:0] cmd_col = '0;
  logic [2:0]       cmd_len = '0;
  logic             cmd_ilv = 1'b0;
  logic             brk = 1'b0;
  logic             beat_valid, beat_last;
  logic [COL_W-1:0] beat_col;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_col(cmd_col),
    .cmd_len(cmd_len), .cmd_ilv(cmd_ilv), .brk(brk),
    .beat_valid(beat_valid), .beat_col(beat_col), .beat_last(beat_last)
  );

  function automatic int exp_len(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return PAGE;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int s, input int k, input int len, input bit ilv);
    int off = s % len;
    int base = s - off;
    if (ilv) return base + (off ^ (k % len));
    return base + ((off + k) % len);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    cyc++;
  endtask

  task automatic launch(input int s, input int code, input bit ilv);
    cmd_col = COL_W'(s); cmd_len = 3'(code); cmd_ilv = ilv; cmd_go = 1'b1;
    tick;
    cmd_go = 1'b0;
    // scramble mode inputs: R10 says they must not matter now
    cmd_col = ~COL_W'(s); cmd_len = 3'(code) ^ 3'b101; cmd_ilv = ~ilv;
  endtask

  task automatic beat(input int s, input int k, input int len, input bit ilv, input bit fixed);
    chk("R2 valid", int'(beat_valid), 1);
    chk(ilv ? "R5/R10 col" : "R4/R10 col", int'(beat_col), exp_col(s, k, len, ilv));
    chk(fixed ? "R6 last" : "R7 no last", int'(beat_last), int'(fixed && k == len - 1));
  endtask

  task automatic full_burst(input int s, input int code, input bit ilv);
    int len = exp_len(code);
    launch(s, code, ilv);
    for (int k = 0; k < len; k++) begin
      beat(s, k, len, ilv, 1'b1);
      tick;
    end
    chk("R3 end", int'(beat_valid), 0);
  endtask

  initial begin
    tick;
    chk("R1 reset valid", int'(beat_valid), 0);
    chk("R1 reset last", int'(beat_last), 0);
    tick; tick;
    rst_n = 1'b1;
    tick; tick;
    chk("R1 idle valid", int'(beat_valid), 0);

    // R3 R4 R5 R6 R10 sweep over lengths, orders and start columns
    for (int code = 0; code < 7; code++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int i = 0; i < 28; i++)
          full_burst(i < 16 ? i : 484 + i, code, ilv[0]);

    // R7 full page linear, wrap 511 -> 0, then stop (R8)
    launch(505, 7, 1'b0);
    for (int k = 0; k < 520; k++) begin
      beat(505, k, PAGE, 1'b0, 1'b0);
      if (k == 519) brk = 1'b1;
      tick;
    end
    brk = 1'b0;
    chk("R8 stop page", int'(beat_valid), 0);

    // R7 full page interleaved, restarted by a new command (R9)
    launch(300, 7, 1'b1);
    for (int k = 0; k < 40; k++) begin
      beat(300, k, PAGE, 1'b1, 1'b0);
      tick;
    end
    full_burst(77, 2, 1'b0);

    // R8 stop mid fixed burst
    launch(10, 3, 1'b0);
    for (int k = 0; k < 3; k++) begin
      beat(10, k, 8, 1'b0, 1'b1);
      if (k == 2) brk = 1'b1;
      tick;
    end
    brk = 1'b0;
    chk("R8 stop fixed", int'(beat_valid), 0);
    // R8 stop while idle
    brk = 1'b1; tick; brk = 1'b0; tick;
    chk("R8 idle stop", int'(beat_valid), 0);

    // R9 restart with simultaneous stop: command wins
    launch(16, 3, 1'b0);
    for (int k = 0; k < 3; k++) begin
      beat(16, k, 8, 1'b0, 1'b1);
      tick;
    end
    brk = 1'b1;
    launch(37, 1, 1'b1);
    brk = 1'b0;
    chk("R9 restart valid", int'(beat_valid), 1);
    chk("R9 restart col", int'(beat_col), 37);
    chk("R9 restart last", int'(beat_last), 0);
    tick;
    chk("R9 second col", int'(beat_col), 36);
    chk("R9 second last", int'(beat_last), 1);
    tick;
    chk("R9 end", int'(beat_valid), 0);

    // R9 command on the last beat: no gap
    launch(3, 1, 1'b0);
    beat(3, 0, 2, 1'b0, 1'b1);
    tick;
    beat(3, 1, 2, 1'b0, 1'b1);
    launch(100, 0, 1'b0);
    chk("R9 b2b valid", int'(beat_valid), 1);
    chk("R9 b2b col", int'(beat_col), 100);
    chk("R9 b2b last", int'(beat_last), 1);
    tick;
    chk("R9 b2b end", int'(beat_valid), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule